// File: doc/BRIEF.md
# Rendering Command Packet Field Tagger

The block sits on a 32-bit word stream that carries rendering command packets and marks every word with the part it plays in its packet. A packet opens with four header words. The first is a command word that selects a primitive type and several mode fields. The second holds a plane mask in its upper half and a primitive count in its lower half. The third must be zero, and the fourth is an update-method word. The mode fields in the command word decide which optional context words follow for the packet as a whole. They also decide which words repeat for each primitive and how many times, so the packet length is known only after the command word has been decoded. The parser walks these groups, counts primitives down from the header count and emits each word once, unchanged, with a five-bit role code beside it.

The control is a six-state machine. `ST_CMD` waits for a command word and always moves to `ST_COUNT`, then to `ST_ZERO`, then to `ST_UPDATE`. From `ST_UPDATE` it moves to `ST_CTX` when any packet-level context word is selected. Otherwise it moves to `ST_PRIM` when the count is nonzero, and otherwise back to `ST_CMD`, ending the packet. `ST_CTX` leaves on its last selected word, going to `ST_PRIM` or, when the count is zero, to `ST_CMD`. `ST_PRIM` returns to `ST_CMD` on the last word of the last primitive. A state moves only on a cycle in which a word is accepted.

A packet with an unknown primitive code or a nonzero third word is walked to its computed end with its words suppressed, and an error flag is set. Rasterising, pixel operations and memory traffic belong to other blocks.

Top module: `pcp_parser`

## Requirements
- R1: After reset out_valid, pkt_done and err are low, in_ready is high, and the first accepted word is treated as a command word.
- R2: The four header words carry roles 0 (command), 1 (plane mask and count), 2 (zero word) and 3 (update method), in that order.
- R3: Packet-level context words follow the header in this order, each only when selected: role 4 line width when bits [11:10]=1; role 5 XY mask when bits [9:8]=1; roles 6 and 7 clip min and clip max when bit 19 is set; role 8 constant colour when bits [5:4]=1; role 9 constant depth when bits [7:6]=1.
- R4: Each primitive takes words in this order: roles 10 and 11 (mask, mask address) when bits [9:8]=2; the data words, role 12; role 13 line width when bits [11:10]=2; role 14 halfspace word when bit 31 is set; role 15 colour, one word when bits [5:4]=2 and three when 3; role 16 depth, under the same rule on bits [7:6].
- R5: The number of data words per primitive follows command bits [3:0]: code 0 gives 1, code 1 gives 2, code 2 gives 3, codes 5, 6 and 7 give 2, and code 8 gives 1.
- R6: The primitive count is bits [15:0] of the second header word. The primitive group repeats that many times, and a count of zero gives a packet with no primitive words.
- R7: Value 3 in the XY-mask or line-width field selects no words, and bits 21 and 23 do not change the role sequence.
- R8: Each accepted word appears on out_data, unchanged, one cycle after acceptance with out_valid high and its role on out_role. A cycle with no input word gives out_valid low.
- R9: pkt_done is a one-cycle pulse in the output cycle of the last word of a packet, and the next accepted word is a command word.
- R10: A primitive code outside {0,1,2,5,6,7,8} sets err in the output cycle of the command word. That word and every later word of the packet are suppressed, and the packet length is computed with one data word per primitive.
- R11: A nonzero third header word sets err in its own output cycle. That word and the rest of the packet are suppressed.
- R12: err stays set through the end of the packet and the following idle cycles. It is updated only when the next command word is accepted, and then goes low if that command is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted (always high) |
| in_data | input | 32 | Input packet word |
| out_valid | output | 1 | Tagged word present |
| out_role | output | 5 | Role code of the tagged word |
| out_data | output | 32 | Tagged word, unchanged |
| pkt_done | output | 1 | Last word of a packet |
| err | output | 1 | Malformed packet flag |

## Verification
Every result of this block is registered once. The role, data, done and error outputs for a word accepted at a rising edge therefore appear right after that edge and stay until the next one. The bench drives each word at the falling edge and reads all four results one nanosecond after the following rising edge, so it compares against the word it has just sent. Idle cycles inserted inside a packet are read at the same offset, and they must show no output word and no done pulse. The err value is compared after every word, including the command word that clears it.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

    localparam int WORD_W     = 32;
    localparam int ROLE_W     = 5;
    localparam int CTX_SLOTS  = 6;
    localparam int PRIM_SLOTS = 7;
    localparam int REP_W      = 2;

    // command word field positions
    localparam int PRIM_LSB = 0;
    localparam int RGB_LSB  = 4;
    localparam int Z_LSB    = 6;
    localparam int XY_LSB   = 8;
    localparam int LW_LSB   = 10;
    localparam int CLIP_BIT = 19;
    localparam int HS_BIT   = 31;

    localparam logic [1:0] MODE_OFF    = 2'd0;
    localparam logic [1:0] MODE_PKT    = 2'd1;
    localparam logic [1:0] MODE_PRIM   = 2'd2;
    localparam logic [1:0] MODE_SMOOTH = 2'd3;

    // packet-level slot order
    localparam int CX_LW      = 0;
    localparam int CX_XY      = 1;
    localparam int CX_CLIPMIN = 2;
    localparam int CX_CLIPMAX = 3;
    localparam int CX_RGB     = 4;
    localparam int CX_Z       = 5;

    // primitive-level slot order
    localparam int PS_XYMASK = 0;
    localparam int PS_XYADDR = 1;
    localparam int PS_DATA   = 2;
    localparam int PS_LW     = 3;
    localparam int PS_HS     = 4;
    localparam int PS_RGB    = 5;
    localparam int PS_Z      = 6;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_CMD        = 5'd0,
        ROLE_COUNT      = 5'd1,
        ROLE_ZERO       = 5'd2,
        ROLE_UPDATE     = 5'd3,
        ROLE_PK_LW      = 5'd4,
        ROLE_PK_XYMASK  = 5'd5,
        ROLE_PK_CLIPMIN = 5'd6,
        ROLE_PK_CLIPMAX = 5'd7,
        ROLE_PK_RGB     = 5'd8,
        ROLE_PK_Z       = 5'd9,
        ROLE_PR_XYMASK  = 5'd10,
        ROLE_PR_XYADDR  = 5'd11,
        ROLE_PR_DATA    = 5'd12,
        ROLE_PR_LW      = 5'd13,
        ROLE_PR_HS      = 5'd14,
        ROLE_PR_RGB     = 5'd15,
        ROLE_PR_Z       = 5'd16
    } role_e;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_COUNT,
        ST_ZERO,
        ST_UPDATE,
        ST_CTX,
        ST_PRIM
    } pstate_e;

    typedef struct packed {
        logic                                legal;
        logic [CTX_SLOTS-1:0]                ctx_mask;
        logic [PRIM_SLOTS-1:0]               prim_mask;
        logic [PRIM_SLOTS-1:0][REP_W-1:0]    prim_len;
    } cmd_cfg_t;

endpackage

// File: rtl/pcp_decode.sv
module pcp_decode
    import pcp_pkg::*;
(
    input  logic [3:0] prim_code,
    input  logic [1:0] rgb_mode,
    input  logic [1:0] z_mode,
    input  logic [1:0] xy_mode,
    input  logic [1:0] lw_mode,
    input  logic       clip_en,
    input  logic       hs_en,
    output cmd_cfg_t   cfg
);

    logic [REP_W-1:0] data_len;
    logic             legal;

    always_comb begin
        legal    = 1'b1;
        data_len = 2'd1;
        unique case (prim_code)
            4'd0:             data_len = 2'd1;
            4'd1:             data_len = 2'd2;
            4'd2:             data_len = 2'd3;
            4'd5, 4'd6, 4'd7: data_len = 2'd2;
            4'd8:             data_len = 2'd1;
            default: begin
                legal    = 1'b0;
                data_len = 2'd1;
            end
        endcase
    end

    always_comb begin
        cfg       = '0;
        cfg.legal = legal;

        cfg.ctx_mask[CX_LW]      = (lw_mode == MODE_PKT);
        cfg.ctx_mask[CX_XY]      = (xy_mode == MODE_PKT);
        cfg.ctx_mask[CX_CLIPMIN] = clip_en;
        cfg.ctx_mask[CX_CLIPMAX] = clip_en;
        cfg.ctx_mask[CX_RGB]     = (rgb_mode == MODE_PKT);
        cfg.ctx_mask[CX_Z]       = (z_mode == MODE_PKT);

        for (int s = 0; s < PRIM_SLOTS; s++) begin
            cfg.prim_len[s] = 2'd1;
        end

        cfg.prim_mask[PS_XYMASK] = (xy_mode == MODE_PRIM);
        cfg.prim_mask[PS_XYADDR] = (xy_mode == MODE_PRIM);
        cfg.prim_mask[PS_DATA]   = 1'b1;
        cfg.prim_len[PS_DATA]    = data_len;
        cfg.prim_mask[PS_LW]     = (lw_mode == MODE_PRIM);
        cfg.prim_mask[PS_HS]     = hs_en;
        cfg.prim_mask[PS_RGB]    = (rgb_mode == MODE_PRIM) || (rgb_mode == MODE_SMOOTH);
        cfg.prim_len[PS_RGB]     = (rgb_mode == MODE_SMOOTH) ? 2'd3 : 2'd1;
        cfg.prim_mask[PS_Z]      = (z_mode == MODE_PRIM) || (z_mode == MODE_SMOOTH);
        cfg.prim_len[PS_Z]       = (z_mode == MODE_SMOOTH) ? 2'd3 : 2'd1;
    end

endmodule

// File: rtl/pcp_lowest.sv
module pcp_lowest #(
    parameter  int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end

    assign onehot = vec & (~vec + N'(1));

endmodule

// File: rtl/pcp_prim_count.sv
module pcp_prim_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero,
    output logic             is_one
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pcp_parser.sv
module pcp_parser
    import pcp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    output logic [ROLE_W-1:0] out_role,
    output logic [WORD_W-1:0] out_data,
    output logic              pkt_done,
    output logic              err
);

    localparam int CTX_IW  = $clog2(CTX_SLOTS);
    localparam int PRIM_IW = $clog2(PRIM_SLOTS);

    pstate_e               state_q, state_d;
    cmd_cfg_t              cfg_d, cfg_q;
    logic [CTX_SLOTS-1:0]  ctx_left_q, ctx_rest, ctx_oh;
    logic [PRIM_SLOTS-1:0] prim_left_q, prim_rest, prim_oh;
    logic [CTX_IW-1:0]     ctx_idx;
    logic [PRIM_IW-1:0]    prim_idx;
    logic [REP_W-1:0]      rep_q;
    logic                  slot_end, group_end;
    logic                  cnt_zero, cnt_one;
    logic                  done_c, drop_c, err_c;
    role_e                 role_c;

    assign in_ready = 1'b1;

    pcp_decode u_decode (
        .prim_code (in_data[PRIM_LSB +: 4]),
        .rgb_mode  (in_data[RGB_LSB +: 2]),
        .z_mode    (in_data[Z_LSB +: 2]),
        .xy_mode   (in_data[XY_LSB +: 2]),
        .lw_mode   (in_data[LW_LSB +: 2]),
        .clip_en   (in_data[CLIP_BIT]),
        .hs_en     (in_data[HS_BIT]),
        .cfg       (cfg_d)
    );

    pcp_lowest #(.N(CTX_SLOTS)) u_ctx_pick (
        .vec    (ctx_left_q),
        .onehot (ctx_oh),
        .idx    (ctx_idx)
    );

    pcp_lowest #(.N(PRIM_SLOTS)) u_prim_pick (
        .vec    (prim_left_q),
        .onehot (prim_oh),
        .idx    (prim_idx)
    );

    pcp_prim_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (in_valid && (state_q == ST_COUNT)),
        .load_val (in_data[CNT_W-1:0]),
        .dec      (in_valid && (state_q == ST_PRIM) && group_end),
        .is_zero  (cnt_zero),
        .is_one   (cnt_one)
    );

    assign ctx_rest  = ctx_left_q & ~ctx_oh;
    assign prim_rest = prim_left_q & ~prim_oh;
    assign slot_end  = ((rep_q + REP_W'(1)) == cfg_q.prim_len[prim_idx]);
    assign group_end = slot_end && (prim_rest == '0);

    // next state, role and flags
    always_comb begin
        state_d = state_q;
        done_c  = 1'b0;
        role_c  = ROLE_CMD;
        drop_c  = err;
        err_c   = err;
        unique case (state_q)
            ST_CMD: begin
                role_c  = ROLE_CMD;
                drop_c  = !cfg_d.legal;
                err_c   = !cfg_d.legal;
                state_d = ST_COUNT;
            end
            ST_COUNT: begin
                role_c  = ROLE_COUNT;
                state_d = ST_ZERO;
            end
            ST_ZERO: begin
                role_c = ROLE_ZERO;
                if (in_data != '0) begin
                    drop_c = 1'b1;
                    err_c  = 1'b1;
                end
                state_d = ST_UPDATE;
            end
            ST_UPDATE: begin
                role_c = ROLE_UPDATE;
                if (cfg_q.ctx_mask != '0) begin
                    state_d = ST_CTX;
                end else if (!cnt_zero) begin
                    state_d = ST_PRIM;
                end else begin
                    state_d = ST_CMD;
                    done_c  = 1'b1;
                end
            end
            ST_CTX: begin
                role_c = role_e'(ROLE_W'(ROLE_PK_LW) + ROLE_W'(ctx_idx));
                if (ctx_rest == '0) begin
                    if (!cnt_zero) begin
                        state_d = ST_PRIM;
                    end else begin
                        state_d = ST_CMD;
                        done_c  = 1'b1;
                    end
                end
            end
            ST_PRIM: begin
                role_c = role_e'(ROLE_W'(ROLE_PR_XYMASK) + ROLE_W'(prim_idx));
                if (group_end && cnt_one) begin
                    state_d = ST_CMD;
                    done_c  = 1'b1;
                end
            end
            default: state_d = ST_CMD;
        endcase
        if (!in_valid) begin
            state_d = state_q;
            done_c  = 1'b0;
            err_c   = err;
        end
    end

    // state register and walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_CMD;
            cfg_q       <= '0;
            ctx_left_q  <= '0;
            prim_left_q <= '0;
            rep_q       <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                unique case (state_q)
                    ST_CMD: cfg_q <= cfg_d;
                    ST_UPDATE: begin
                        ctx_left_q  <= cfg_q.ctx_mask;
                        prim_left_q <= cfg_q.prim_mask;
                        rep_q       <= '0;
                    end
                    ST_CTX: ctx_left_q <= ctx_rest;
                    ST_PRIM: begin
                        if (slot_end) begin
                            rep_q       <= '0;
                            prim_left_q <= (prim_rest == '0) ? cfg_q.prim_mask : prim_rest;
                        end else begin
                            rep_q <= rep_q + REP_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_role  <= '0;
            out_data  <= '0;
            pkt_done  <= 1'b0;
            err       <= 1'b0;
        end else begin
            out_valid <= in_valid && !drop_c;
            out_role  <= role_c;
            out_data  <= in_data;
            pkt_done  <= done_c;
            err       <= err_c;
        end
    end

endmodule

// File: rtl/pcp_parser_chk.sv
module pcp_parser_chk
    import pcp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_data,
    input logic              out_valid,
    input logic [ROLE_W-1:0] out_role,
    input logic [WORD_W-1:0] out_data,
    input logic              pkt_done,
    input logic              err
);

    // R8: a tagged word needs an accepted word one cycle earlier
    a_r8_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R8: data passes unchanged
    a_r8_data_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == $past(in_data)));

    // R9: done is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    // R9 / R2: the word right after a packet end is a command word
    a_r9_cmd_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(pkt_done)) |-> (out_role == 5'(ROLE_CMD)));

    // R2: role codes stay within the defined set
    a_r2_role_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_role <= 5'(ROLE_PR_Z)));

    // R10 / R11: a suppressed word only happens with err set
    a_r10_drop_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !out_valid) |-> err);

    // R12: err clears only with a tagged command word
    a_r12_err_clear_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> (out_valid && (out_role == 5'(ROLE_CMD))));

endmodule

bind pcp_parser pcp_parser_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_role  (out_role),
    .out_data  (out_data),
    .pkt_done  (pkt_done),
    .err       (err)
);

// File: tb/pcp_parser_test.sv
`timescale 1ns/1ps
module pcp_parser_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [4:0]  out_role;
    logic [31:0] out_data;
    logic        pkt_done;
    logic        err;

    int checks = 0;
    int errors = 0;
    int exp_roles [0:255];
    int n_exp;

    always #2 clk = ~clk;

    pcp_parser uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_role  (out_role),
        .out_data  (out_data),
        .pkt_done  (pkt_done),
        .err       (err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int r);
        exp_roles[n_exp] = r;
        n_exp++;
    endtask

    function automatic int data_words(input logic [3:0] code);
        case (code)
            4'd0:             return 1;
            4'd1:             return 2;
            4'd2:             return 3;
            4'd5, 4'd6, 4'd7: return 2;
            default:          return 1;
        endcase
    endfunction

    function automatic bit legal_code(input logic [3:0] code);
        return (code inside {4'd0, 4'd1, 4'd2, 4'd5, 4'd6, 4'd7, 4'd8});
    endfunction

    // expected role list computed from the requirement text
    task automatic build(input logic [31:0] cmd, input int cnt);
        logic [1:0] rgb, zm, xy, lw;
        rgb = cmd[5:4];
        zm  = cmd[7:6];
        xy  = cmd[9:8];
        lw  = cmd[11:10];
        n_exp = 0;
        for (int r = 0; r < 4; r++) push(r);
        if (lw == 2'd1) push(4);
        if (xy == 2'd1) push(5);
        if (cmd[19]) begin push(6); push(7); end
        if (rgb == 2'd1) push(8);
        if (zm == 2'd1) push(9);
        for (int p = 0; p < cnt; p++) begin
            if (xy == 2'd2) begin push(10); push(11); end
            for (int d = 0; d < data_words(cmd[3:0]); d++) push(12);
            if (lw == 2'd2) push(13);
            if (cmd[31]) push(14);
            if (rgb == 2'd2) push(15);
            if (rgb == 2'd3) begin push(15); push(15); push(15); end
            if (zm == 2'd2) push(16);
            if (zm == 2'd3) begin push(16); push(16); push(16); end
        end
    endtask

    task automatic run_pkt(input logic [31:0] cmd, input int cnt,
                           input logic [31:0] zw, input int gap, input string req);
        int dstart;
        logic [31:0] word;
        build(cmd, cnt);
        dstart = !legal_code(cmd[3:0]) ? 0 : ((zw != 0) ? 2 : 1000);
        for (int i = 0; i < n_exp; i++) begin
            if (i == 0)      word = cmd;
            else if (i == 1) word = {16'h3C3C, cnt[15:0]};
            else if (i == 2) word = zw;
            else             word = 32'h7000_0000 + i * 13 + cnt;
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = word;
            @(posedge clk);
            #1;
            check(req, "out_valid", {31'b0, out_valid}, {31'b0, (i < dstart)});
            if (i < dstart) begin
                check(req, "out_role", {27'b0, out_role}, exp_roles[i]);
                check(req, "out_data", out_data, word);
            end
            check(req, "pkt_done", {31'b0, pkt_done}, {31'b0, (i == n_exp - 1)});
            check(req, "err", {31'b0, err}, {31'b0, (i >= dstart)});
            if (gap > 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                for (int g = 0; g < gap; g++) begin
                    @(posedge clk);
                    #1;
                    check("R8", "idle out_valid", {31'b0, out_valid}, 32'd0);
                    check("R9", "idle pkt_done", {31'b0, pkt_done}, 32'd0);
                    check("R12", "idle err", {31'b0, err}, {31'b0, (i >= dstart)});
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "out_valid", {31'b0, out_valid}, 32'd0);
        check("R1", "pkt_done", {31'b0, pkt_done}, 32'd0);
        check("R1", "err", {31'b0, err}, 32'd0);
        check("R1", "in_ready", {31'b0, in_ready}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: first packet after reset, plain points
        run_pkt(32'h0000_0000, 1, 32'h0, 0, "R1/R2");

        // R5 R10 R12: sweep all primitive codes, legal packet follows each
        for (int c = 0; c < 16; c++) begin
            run_pkt(32'(c), 2, 32'h0, 0, "R5/R10");
            run_pkt(32'h0000_0002, 1, 32'h0, 0, "R12");
        end

        // R3 R4 R7: sweep all mode fields with clip and halfspace flags
        for (int rgb = 0; rgb < 4; rgb++)
            for (int zm = 0; zm < 4; zm++)
                for (int xy = 0; xy < 4; xy++)
                    for (int lw = 0; lw < 4; lw++)
                        for (int f = 0; f < 4; f++) begin
                            logic [31:0] cmd;
                            cmd = 32'h1 | (32'(rgb) << 4) | (32'(zm) << 6)
                                | (32'(xy) << 8) | (32'(lw) << 10)
                                | (32'(f & 1) << 19) | (32'((f >> 1) & 1) << 31);
                            if (lw[0]) cmd = cmd | 32'h00A0_0000;
                            run_pkt(cmd, 2, 32'h0, 0, "R3/R4/R7");
                        end

        // R6: counts zero, one and several
        run_pkt(32'h0000_0002, 0, 32'h0, 0, "R6");
        run_pkt(32'h0008_0450, 0, 32'h0, 0, "R6");
        run_pkt(32'h8000_0AF2, 1, 32'h0, 0, "R6");
        run_pkt(32'h0000_02F7, 3, 32'h0, 0, "R6");
        run_pkt(32'h0000_0008, 5, 32'h0, 0, "R6");

        // R8 R9: idle cycles inside a packet
        run_pkt(32'h8008_09F1, 2, 32'h0, 2, "R8/R9");

        // R11 R12: nonzero zero word, then legal packet clears err
        run_pkt(32'h0000_0031, 2, 32'h0000_0100, 1, "R11");
        run_pkt(32'h0000_0001, 1, 32'h0, 0, "R12");
        run_pkt(32'h0008_0005, 0, 32'h8000_0000, 0, "R11");
        run_pkt(32'h0000_000E, 1, 32'h0, 1, "R10/R12");
        run_pkt(32'h0000_0006, 2, 32'h0, 0, "R12");

        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule